// File: doc/BRIEF.md
# Walking-Bit Memory Self-Test Engine

This block is a built-in self-test engine that exercises a region of memory through a plain synchronous master port. After a start pulse it picks up a base address, a region length in words, a polarity (a single set bit on a cleared background, or a single cleared bit on a set background) and a mask of access widths. For every enabled width it visits each word of the region in turn. At each word it runs one write, read-back and compare step for every bit position of that width.

The engine waits for the memory's read-valid strobe before it compares, so it works behind any read latency of one cycle or more. The first word that reads back differently from what was written stops the run. The engine then holds the failing address, the written value and the returned value, and raises done together with fail. A run that finds no mismatch ends with done and pass.

Top module: `walkbit_bist`

## Requirements
- R1: While reset is high, and after it, until the first accepted start, done, pass, fail, mem_we and mem_re are all low.
- R2: With cfg_mode = 0 (single set bit), each written word equals 1 shifted left by the current bit position. Every bit above that position is zero.
- R3: With cfg_mode = 1 (single cleared bit), each written word has every bit below the access width set except the current bit position. Every bit at or above the access width is zero. For example, width 16 at bit 0 gives 0x0000FFFE.
- R4: Within one word the bit position runs from 0 up to width-1. After that the address steps by one from cfg_base through cfg_base+cfg_len-1, wrapping modulo 2^AW.
- R5: Bit 0 of cfg_wmask enables width 8, bit 1 enables width 16 and bit 2 enables width 32. Enabled widths run in ascending order, each as a full sweep of the region. A run without mismatch issues exactly cfg_len times the sum of the enabled widths writes.
- R6: Each write cycle (mem_we) is followed in the next cycle by a read request (mem_re) of the same address. mem_we and mem_re are never high together. The comparison uses only the mem_rdata that comes with mem_rvalid, so any read latency of one cycle or more is accepted.
- R7: At the first read that differs from the written word, done and fail go high and pass stays low. fail_addr, fail_exp and fail_act hold that address, the written word and the returned word. No further memory access occurs.
- R8: A run with no mismatch ends with done and pass high, fail low, and no further memory access.
- R9: A start with cfg_wmask = 0 or cfg_len = 0 raises done and pass on the next cycle, with no memory access.
- R10: A start that arrives during a run is ignored, and the run finishes with its original settings. A start accepted after a finished run clears done and fail and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when idle or finished |
| cfg_mode | input | 1 | 0 = single set bit, 1 = single cleared bit |
| cfg_wmask | input | 3 | Width enables: bit0 = 8, bit1 = 16, bit2 = 32 |
| cfg_base | input | AW | First word address of the region |
| cfg_len | input | AW+1 | Region length in words |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 32 | Memory read data |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | 32 | Word written at the mismatch |
| fail_act | output | 32 | Word read back at the mismatch |

## Verification
The hardest cases to reach from the ports are a fault that only shows up at one width, and a fault that sits above the active width. The bench memory model forces chosen bits at chosen addresses. A bit stuck low above bit 7 survives the byte sweep and is caught only in the later word sweep. A bit stuck high above bit 15 shows that narrow widths leave the upper bits cleared. An independent model in the bench computes the full write order and the first failing step, and every write is compared against it at varying read latencies.

// File: rtl/walkbit_pkg.sv
package walkbit_pkg;

    localparam int DW = 32;
    localparam int NW = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_READ,
        S_WAIT,
        S_DONE
    } state_t;

    typedef enum logic {
        MODE_ONES  = 1'b0,
        MODE_ZEROS = 1'b1
    } mode_t;

    function automatic logic [5:0] width_of(input logic [1:0] wsel);
        return 6'(8 << wsel);
    endfunction

    function automatic logic [2:0] enabled_above(input logic [2:0] mask, input logic [1:0] cur);
        logic [2:0] keep;
        keep = 3'b110 << cur;
        return mask & keep;
    endfunction

    function automatic logic [1:0] lowest_set(input logic [2:0] mask);
        if (mask[0]) return 2'd0;
        if (mask[1]) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [DW-1:0] make_pattern(input mode_t m, input int unsigned w,
                                                  input logic [4:0] b);
        logic [DW-1:0] one;
        logic [DW-1:0] lanes;
        one   = DW'(1) << b;
        lanes = (w >= DW) ? '1 : ((DW'(1) << w) - DW'(1));
        return (m == MODE_ONES) ? one : (~one & lanes);
    endfunction

endpackage

// File: rtl/walkbit_pattern.sv
module walkbit_pattern
    import walkbit_pkg::*;
(
    input  mode_t          mode,
    input  logic [1:0]     wsel,
    input  logic [4:0]     bitpos,
    output logic [DW-1:0]  pattern
);

    logic [DW-1:0] cand [NW];

    for (genvar gi = 0; gi < NW; gi++) begin : g_width
        assign cand[gi] = make_pattern(mode, 8 << gi, bitpos);
    end

    always_comb begin
        pattern = '0;
        for (int i = 0; i < NW; i++) begin
            if (wsel == 2'(i)) pattern = cand[i];
        end
    end

endmodule

// File: rtl/walkbit_cursor.sv
module walkbit_cursor
    import walkbit_pkg::*;
#(
    parameter int AW = 8,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [2:0]    cfg_mask,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    output logic [AW-1:0] addr,
    output logic [1:0]    wsel,
    output logic [4:0]    bitpos,
    output logic [5:0]    width,
    output logic          last
);

    logic [2:0]    mask_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] off_q;
    logic [1:0]    wsel_q;
    logic [4:0]    bit_q;
    logic          last_bit, last_off, last_w;

    assign width    = width_of(wsel_q);
    assign last_bit = ({1'b0, bit_q} == width - 6'd1);
    assign last_off = (off_q == len_q - LW'(1));
    assign last_w   = (enabled_above(mask_q, wsel_q) == 3'b000);
    assign last     = last_bit && last_off && last_w;
    assign addr     = base_q + off_q[AW-1:0];
    assign wsel     = wsel_q;
    assign bitpos   = bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
            len_q  <= '0;
            off_q  <= '0;
            wsel_q <= '0;
            bit_q  <= '0;
        end else if (load) begin
            mask_q <= cfg_mask;
            base_q <= cfg_base;
            len_q  <= cfg_len;
            off_q  <= '0;
            bit_q  <= '0;
            wsel_q <= lowest_set(cfg_mask);
        end else if (step) begin
            if (!last_bit) begin
                bit_q <= bit_q + 5'd1;
            end else begin
                bit_q <= '0;
                if (!last_off) begin
                    off_q <= off_q + LW'(1);
                end else begin
                    off_q  <= '0;
                    wsel_q <= lowest_set(enabled_above(mask_q, wsel_q));
                end
            end
        end
    end

    // R4: bit position always stays inside the active width
    a_r4_bit_in_width: assert property (@(posedge clk) disable iff (rst)
        {1'b0, bit_q} < width);

    // R4: bit position advances by one within a word
    a_r4_bit_steps: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !last_bit) |=> (bit_q == $past(bit_q) + 5'd1));

endmodule

// File: rtl/walkbit_result.sv
module walkbit_result
    import walkbit_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] exp_word,
    input  logic [DW-1:0] act_word,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (capture) begin
            fail_addr <= addr;
            fail_exp  <= exp_word;
            fail_act  <= act_word;
        end
    end

    // R7: a captured record really is a miscompare
    a_r7_record_differs: assert property (@(posedge clk) disable iff (rst)
        capture |=> (fail_exp != fail_act));

endmodule

// File: rtl/walkbit_bist.sv
module walkbit_bist
    import walkbit_pkg::*;
#(
    parameter int AW = 8,
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cfg_mode,
    input  logic [2:0]    cfg_wmask,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_rvalid,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [DW-1:0] fail_exp,
    output logic [DW-1:0] fail_act
);

    state_t        state;
    mode_t         mode_q;
    logic          done_q, fail_q;
    logic          accept, trivial, mismatch, last, step, capture;
    logic [1:0]    wsel;
    logic [4:0]    bitpos;
    logic [5:0]    width;
    logic [DW-1:0] pattern;

    assign accept   = start && (state == S_IDLE || state == S_DONE);
    assign trivial  = (cfg_wmask == 3'b000) || (cfg_len == '0);
    assign mismatch = (mem_rdata != pattern);
    assign step     = (state == S_WAIT) && mem_rvalid && !mismatch && !last;
    assign capture  = (state == S_WAIT) && mem_rvalid && mismatch;

    walkbit_cursor #(.AW(AW)) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .step     (step),
        .cfg_mask (cfg_wmask),
        .cfg_base (cfg_base),
        .cfg_len  (cfg_len),
        .addr     (mem_addr),
        .wsel     (wsel),
        .bitpos   (bitpos),
        .width    (width),
        .last     (last)
    );

    walkbit_pattern u_pattern (
        .mode    (mode_q),
        .wsel    (wsel),
        .bitpos  (bitpos),
        .pattern (pattern)
    );

    walkbit_result #(.AW(AW)) u_result (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .capture   (capture),
        .addr      (mem_addr),
        .exp_word  (pattern),
        .act_word  (mem_rdata),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            mode_q <= MODE_ONES;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (accept) begin
            mode_q <= mode_t'(cfg_mode);
            done_q <= trivial;
            fail_q <= 1'b0;
            state  <= trivial ? S_DONE : S_WRITE;
        end else begin
            case (state)
                S_WRITE: state <= S_READ;
                S_READ:  state <= S_WAIT;
                S_WAIT: begin
                    if (mem_rvalid) begin
                        if (mismatch) begin
                            fail_q <= 1'b1;
                            done_q <= 1'b1;
                            state  <= S_DONE;
                        end else if (last) begin
                            done_q <= 1'b1;
                            state  <= S_DONE;
                        end else begin
                            state <= S_WRITE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_we    = (state == S_WRITE);
    assign mem_re    = (state == S_READ);
    assign mem_wdata = pattern;
    assign done      = done_q;
    assign fail      = fail_q;
    assign pass      = done_q && !fail_q;

    // R6: a read of the same address follows every write
    a_r6_read_after_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_re && mem_addr == $past(mem_addr)));

    // R6: never a write and a read in one cycle
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R7, R8: the port is quiet once a result is reported
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_we && !mem_re));

    // R2: single set bit
    a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mode_q == MODE_ONES) |-> ($countones(mem_wdata) == 1));

    // R3: single cleared bit inside the active width
    a_r3_one_cold: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mode_q == MODE_ZEROS) |-> ($countones(mem_wdata) == int'(width) - 1));

    // R9: empty configuration finishes at once with a pass
    a_r9_trivial_pass: assert property (@(posedge clk) disable iff (rst)
        (accept && trivial) |=> (done && pass && !fail));

    // R7: fail holds until a new run is accepted
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    // R10: a start during a run does not restart it
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (start && state == S_READ) |=> (state == S_WAIT));

endmodule

// File: tb/walkbit_bist_bench.sv
module walkbit_bist_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int MAXW = 2048;

    typedef struct packed {
        logic [2:0] mask;
        logic       mode;
        logic [7:0] base;
        logic [8:0] len;
        logic       st_en;
        logic [7:0] st_addr;
        logic [4:0] st_bit;
        logic       st_val;
        logic [1:0] lat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'b001, 1'b0, 8'd10,  9'd4, 1'b0, 8'd0,   5'd0,  1'b0, 2'd1},
        '{3'b111, 1'b1, 8'd250, 9'd8, 1'b0, 8'd0,   5'd0,  1'b0, 2'd2},
        '{3'b101, 1'b0, 8'd0,   9'd3, 1'b1, 8'd1,   5'd20, 1'b0, 2'd3},
        '{3'b110, 1'b1, 8'd40,  9'd2, 1'b1, 8'd41,  5'd3,  1'b0, 2'd1},
        '{3'b010, 1'b0, 8'd100, 9'd5, 1'b1, 8'd102, 5'd20, 1'b1, 2'd2},
        '{3'b100, 1'b1, 8'd7,   9'd1, 1'b0, 8'd0,   5'd0,  1'b0, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cfg_mode = 1'b0;
    logic [2:0]    cfg_wmask = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW:0]   cfg_len = '0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_we, mem_re;
    logic [31:0]   mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          done, pass, fail;
    logic [AW-1:0] fail_addr;
    logic [31:0]   fail_exp, fail_act;

    walkbit_bist #(.AW(AW)) u_walkbit_bist (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
        .cfg_wmask(cfg_wmask), .cfg_base(cfg_base), .cfg_len(cfg_len),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .done(done), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model with a forced bit and variable read latency
    logic [31:0] mem [256];
    logic        st_en = 1'b0;
    logic [7:0]  st_addr = '0;
    logic [4:0]  st_bit = '0;
    logic        st_val = 1'b0;
    int          rd_lat = 1;
    int          pend = 0;
    logic [7:0]  pend_addr = '0;

    always @(posedge clk) begin
        logic [31:0] d;
        mem_rvalid <= 1'b0;
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (pend == 1) begin
            d = mem[pend_addr];
            if (st_en && pend_addr == st_addr) d[st_bit] = st_val;
            mem_rdata  <= d;
            mem_rvalid <= 1'b1;
            pend <= 0;
        end else if (pend > 1) begin
            pend <= pend - 1;
        end
        if (mem_re) begin
            pend      <= rd_lat;
            pend_addr <= mem_addr;
        end
    end

    // expected write order
    logic [7:0]  ex_addr [MAXW];
    logic [31:0] ex_data [MAXW];
    int ex_n;
    logic        ex_fail;
    logic [7:0]  ex_faddr;
    logic [31:0] ex_fexp, ex_fact;

    int wr_cnt = 0, rd_cnt = 0, seq_bad = 0;
    always @(negedge clk) begin
        int idx;
        if (mem_we) begin
            idx = wr_cnt - wr_base;
            if (idx >= ex_n || ex_addr[idx] != mem_addr || ex_data[idx] != mem_wdata)
                seq_bad <= seq_bad + 1;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_re) rd_cnt <= rd_cnt + 1;
    end

    int wr_base = 0, rd_base = 0, bad_base = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic build(input vec_t v);
        logic stop;
        stop = 1'b0;
        ex_n = 0;
        ex_fail = 1'b0;
        ex_faddr = '0; ex_fexp = '0; ex_fact = '0;
        for (int wi = 0; wi < 3; wi++) begin
            if (v.mask[wi]) begin
                for (int o = 0; o < int'(v.len); o++) begin
                    for (int b = 0; b < (8 << wi); b++) begin
                        logic [31:0] p, rd;
                        logic [7:0] a;
                        if (!stop) begin
                            a = 8'(int'(v.base) + o);
                            if (v.mode == 1'b0) p = 32'(1) << b;
                            else p = ~(32'(1) << b) & ((wi == 2) ? 32'hFFFF_FFFF : ((32'(1) << (8 << wi)) - 1));
                            ex_addr[ex_n] = a;
                            ex_data[ex_n] = p;
                            ex_n++;
                            rd = p;
                            if (v.st_en && a == v.st_addr) rd[v.st_bit] = v.st_val;
                            if (rd != p) begin
                                stop = 1'b1;
                                ex_fail = 1'b1;
                                ex_faddr = a; ex_fexp = p; ex_fact = rd;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        st_en = v.st_en; st_addr = v.st_addr; st_bit = v.st_bit; st_val = v.st_val;
        rd_lat = int'(v.lat);
        cfg_mode = v.mode; cfg_wmask = v.mask; cfg_base = v.base; cfg_len = v.len;
        wr_base = wr_cnt; rd_base = rd_cnt; bad_base = seq_bad;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        ok = done;
    endtask

    task automatic check_run(input string tag);
        logic ok;
        wait_done(ok);
        check({tag, " R8 run finished"}, 64'(ok), 64'(1));
        repeat (4) @(negedge clk);
        check({tag, " R7 fail flag"}, 64'(fail), 64'(ex_fail));
        check({tag, " R8 pass flag"}, 64'(pass), 64'(!ex_fail));
        check({tag, " R5 write count"}, 64'(wr_cnt - wr_base), 64'(ex_n));
        check({tag, " R6 read count"}, 64'(rd_cnt - rd_base), 64'(ex_n));
        check({tag, " R2 R3 R4 write order and data"}, 64'(seq_bad - bad_base), 64'(0));
        if (ex_fail) begin
            check({tag, " R7 fail_addr"}, 64'(fail_addr), 64'(ex_faddr));
            check({tag, " R7 fail_exp"}, 64'(fail_exp), 64'(ex_fexp));
            check({tag, " R7 fail_act"}, 64'(fail_act), 64'(ex_fact));
        end
    endtask

    initial begin
        wait (cyc >= 190000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        ex_n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", 64'(done), 64'(0));
        check("R1 fail in reset", 64'(fail), 64'(0));
        check("R1 no access in reset", 64'({mem_we, mem_re, pass}), 64'(0));
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", 64'({done, pass, fail, mem_we, mem_re}), 64'(0));

        // table of vectors
        for (int i = 0; i < NV; i++) begin
            build(VECS[i]);
            launch(VECS[i]);
            check_run($sformatf("vec%0d", i));
        end

        // R9: empty width mask
        ex_n = 0;
        launch('{3'b000, 1'b0, 8'd5, 9'd4, 1'b0, 8'd0, 5'd0, 1'b0, 2'd1});
        check("R9 mask zero done", 64'({done, pass, fail}), 64'(3'b110));
        repeat (3) @(negedge clk);
        check("R9 mask zero no access", 64'(wr_cnt - wr_base + rd_cnt - rd_base), 64'(0));

        // R9: empty region
        launch('{3'b111, 1'b1, 8'd5, 9'd0, 1'b0, 8'd0, 5'd0, 1'b0, 2'd1});
        check("R9 length zero done", 64'({done, pass, fail}), 64'(3'b110));
        repeat (3) @(negedge clk);
        check("R9 length zero no access", 64'(wr_cnt - wr_base + rd_cnt - rd_base), 64'(0));

        // R10: start during a run is ignored
        build(VECS[0]);
        launch(VECS[0]);
        repeat (7) @(negedge clk);
        cfg_wmask = 3'b111; cfg_len = 9'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_run("R10 restart ignored");

        // R10: new run after a failure clears fail
        build(VECS[2]);
        launch(VECS[2]);
        check_run("R10 failing run");
        build(VECS[5]);
        launch(VECS[5]);
        check("R10 done cleared by new start", 64'(done), 64'(0));
        check_run("R10 rerun after fail");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule